// File: doc/BRIEF.md
# Vector Memory Sequencer

This block walks through a vector store one entry per enabled cycle and drives the single address that every per-pin memory array (drive, input, direction, control and data-valid) reads in parallel. Each stored entry carries a command field. The sequencer decodes that field in the same cycle the entry is presented, and from it picks the next address. The command can step forward, branch unconditionally, branch on an external condition input, repeat a body with a counted loop, or stop. Because of this, a short program can produce a vector stream that never ends, at one vector per enabled cycle.

A control machine with three states (halted, paused, running) gates the stepping. Software, or an external trigger, starts it from a programmed start address. A pause request freezes the stream in place until a resume request arrives. A halt request, or a stop command in the program, sends the machine back to the halted state and rewinds the address. A clock-enable input paces the stepping from an external clock. The command store is a small internal array that is loaded through a write port.

Top module: `vecseq_top`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, state_o is 0 (halted), valid_o is 0 and addr_o is 0. The state encoding is halted=0, paused=1, running=2.
- R2: valid_o is high only while running with ce_i high and no pause or halt request, and each high cycle emits the vector at addr_o.
- R3: A command word is {op[2:0], count[15:0], target[5:0]}, with op NEXT=0, JUMP=1, JUMP_IF=2, LOOP=3, HALT=4. A NEXT vector is followed by addr_o+1, wrapping at the top of the store.
- R4: A JUMP vector is followed directly by the target address, with no gap cycle.
- R5: A JUMP_IF vector is followed by the target when cond_i is high, and by addr_o+1 otherwise.
- R6: A LOOP with count N>0 branches back to its target N times and then falls through, so the body runs N+1 times. With N=0 it falls through at once. After it falls through, the next LOOP it meets reloads the count.
- R7: A HALT vector is emitted, and the machine then enters the halted state with addr_o equal to start_addr_i.
- R8: A pause request while running stops valid_o in that same cycle and enters the paused state. The address and loop count are frozen. After resume_i the stream continues from the frozen address.
- R9: A halt request in the running or paused state moves to halted with addr_o = start_addr_i, and it wins over a simultaneous pause request.
- R10: From the halted state, start_i or trig_i moves to running, and the first vector is at start_addr_i.
- R11: While running, a cycle with ce_i low emits nothing and leaves addr_o unchanged.
- R12: A word written through the command write port in the halted state changes the flow of the next run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce_i | input | 1 | Step enable from the external pacing clock |
| start_i | input | 1 | Start request |
| trig_i | input | 1 | External start trigger |
| pause_i | input | 1 | Pause request |
| resume_i | input | 1 | Resume request |
| halt_i | input | 1 | Halt request |
| cond_i | input | 1 | External branch condition |
| start_addr_i | input | ADDR_W | Programmed start address |
| cmd_we_i | input | 1 | Command store write enable |
| cmd_waddr_i | input | ADDR_W | Command store write address |
| cmd_wdata_i | input | CMD_W | Command store write data |
| addr_o | output | ADDR_W | Shared vector address |
| valid_o | output | 1 | Vector at addr_o is emitted this cycle |
| state_o | output | 2 | Control state |

## Verification
The bound assertions check on every cycle the rules that tie one cycle to the next. These are the step-by-one and jump targets, the return to the start address after a stop command or a halt request, the frozen address while paused or while ce_i is low, the entry into running from a start or trigger, and the gating of valid_o. The behaviour that spans many cycles can only be shown by the bench's scenarios. These include the exact number of passes through a counted loop, the reload of the count when the loop is met again, the conditional branch under both values of cond_i, and the continuation after resume. The bench compares whole address streams against the expected sequences.

// File: rtl/vecseq_pkg.sv
package vecseq_pkg;
  localparam int OP_W = 3;

  typedef enum logic [1:0] {
    ST_HALT  = 2'd0,
    ST_PAUSE = 2'd1,
    ST_RUN   = 2'd2
  } seq_state_e;

  typedef enum logic [OP_W-1:0] {
    OP_NEXT = 3'd0,
    OP_JUMP = 3'd1,
    OP_JIF  = 3'd2,
    OP_LOOP = 3'd3,
    OP_HALT = 3'd4
  } seq_op_e;
endpackage

// File: rtl/vecseq_cmd_mem.sv
module vecseq_cmd_mem #(
  parameter int ADDR_W = 6,
  parameter int CMD_W  = 25
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [CMD_W-1:0]  wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [CMD_W-1:0]  rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [CMD_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  // asynchronous read: the command decodes in the cycle its vector is emitted
  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/vecseq_loop_ctr.sv
module vecseq_loop_ctr #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             step_i,
  input  logic             is_loop_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             take_o
);
  logic             active_q;
  logic [CNT_W-1:0] cnt_q;

  always_comb begin
    take_o = is_loop_i && (active_q ? (cnt_q != '0) : (cnt_i != '0));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else if (clear_i) begin
      active_q <= 1'b0;
    end else if (step_i && is_loop_i) begin
      if (active_q) begin
        if (cnt_q == '0) active_q <= 1'b0;   // exhausted: fall through, reload on next meet
        else             cnt_q    <= cnt_q - 1'b1;
      end else if (cnt_i != '0) begin
        active_q <= 1'b1;
        cnt_q    <= cnt_i - 1'b1;
      end
    end
  end
endmodule

// File: rtl/vecseq_next_addr.sv
module vecseq_next_addr
  import vecseq_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  seq_op_e           op_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ADDR_W-1:0] tgt_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic              cond_i,
  input  logic              take_loop_i,
  output logic [ADDR_W-1:0] nxt_o
);
  logic [ADDR_W-1:0] inc;

  always_comb begin
    inc = addr_i + 1'b1;
    case (op_i)
      OP_JUMP: nxt_o = tgt_i;
      OP_JIF:  nxt_o = cond_i ? tgt_i : inc;
      OP_LOOP: nxt_o = take_loop_i ? tgt_i : inc;
      OP_HALT: nxt_o = start_addr_i;
      default: nxt_o = inc;
    endcase
  end
endmodule

// File: rtl/vecseq_ctrl.sv
module vecseq_ctrl
  import vecseq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ce_i,
  input  logic       start_i,
  input  logic       trig_i,
  input  logic       pause_i,
  input  logic       resume_i,
  input  logic       halt_i,
  input  logic       halt_op_i,
  output seq_state_e state_o,
  output logic       step_o
);
  seq_state_e st_q, st_d;

  assign step_o  = (st_q == ST_RUN) && ce_i && !pause_i && !halt_i;
  assign state_o = st_q;

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_HALT:  if (start_i || trig_i) st_d = ST_RUN;
      ST_RUN: begin
        if (halt_i)                    st_d = ST_HALT;
        else if (pause_i)              st_d = ST_PAUSE;
        else if (step_o && halt_op_i)  st_d = ST_HALT;
      end
      ST_PAUSE: begin
        if (halt_i)        st_d = ST_HALT;
        else if (resume_i) st_d = ST_RUN;
      end
      default: st_d = ST_HALT;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_HALT;
    else         st_q <= st_d;
  end
endmodule

// File: rtl/vecseq_top.sv
module vecseq_top
  import vecseq_pkg::*;
#(
  parameter int  ADDR_W = 6,
  parameter int  CNT_W  = 16,
  localparam int CMD_W  = OP_W + CNT_W + ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_i,
  input  logic              start_i,
  input  logic              trig_i,
  input  logic              pause_i,
  input  logic              resume_i,
  input  logic              halt_i,
  input  logic              cond_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic              cmd_we_i,
  input  logic [ADDR_W-1:0] cmd_waddr_i,
  input  logic [CMD_W-1:0]  cmd_wdata_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              valid_o,
  output logic [1:0]        state_o
);
  logic [ADDR_W-1:0] addr_q, nxt_addr, cur_tgt;
  logic [CMD_W-1:0]  cur_cmd;
  logic [CNT_W-1:0]  cur_cnt;
  seq_op_e           cur_op;
  seq_state_e        st;
  logic              step, take_loop, loop_clr;

  vecseq_cmd_mem #(.ADDR_W(ADDR_W), .CMD_W(CMD_W)) u_mem (
    .clk_i   (clk_i),
    .we_i    (cmd_we_i),
    .waddr_i (cmd_waddr_i),
    .wdata_i (cmd_wdata_i),
    .raddr_i (addr_q),
    .rdata_o (cur_cmd)
  );

  assign cur_op  = seq_op_e'(cur_cmd[CMD_W-1 -: OP_W]);
  assign cur_cnt = cur_cmd[ADDR_W +: CNT_W];
  assign cur_tgt = cur_cmd[ADDR_W-1:0];

  vecseq_ctrl u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ce_i      (ce_i),
    .start_i   (start_i),
    .trig_i    (trig_i),
    .pause_i   (pause_i),
    .resume_i  (resume_i),
    .halt_i    (halt_i),
    .halt_op_i (cur_op == OP_HALT),
    .state_o   (st),
    .step_o    (step)
  );

  assign loop_clr = halt_i || (st == ST_HALT);

  vecseq_loop_ctr #(.CNT_W(CNT_W)) u_loop (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clear_i   (loop_clr),
    .step_i    (step),
    .is_loop_i (cur_op == OP_LOOP),
    .cnt_i     (cur_cnt),
    .take_o    (take_loop)
  );

  vecseq_next_addr #(.ADDR_W(ADDR_W)) u_nxt (
    .op_i         (cur_op),
    .addr_i       (addr_q),
    .tgt_i        (cur_tgt),
    .start_addr_i (start_addr_i),
    .cond_i       (cond_i),
    .take_loop_i  (take_loop),
    .nxt_o        (nxt_addr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      addr_q <= '0;
    else if (st == ST_HALT || halt_i) addr_q <= start_addr_i;
    else if (step)                    addr_q <= nxt_addr;
  end

  assign addr_o  = addr_q;
  assign valid_o = step;
  assign state_o = st;
endmodule

// File: rtl/vecseq_chk.sv
module vecseq_chk
  import vecseq_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ce_i,
  input logic              start_i,
  input logic              trig_i,
  input logic              pause_i,
  input logic              halt_i,
  input logic [ADDR_W-1:0] start_addr_i,
  input logic [ADDR_W-1:0] addr_o,
  input logic              valid_o,
  input logic [1:0]        state_o,
  input seq_op_e           cur_op,
  input logic [ADDR_W-1:0] cur_tgt
);
  assert_valid_gate_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (state_o == ST_RUN && ce_i));

  assert_next_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && cur_op == OP_NEXT) |=> (addr_o == $past(addr_o) + ADDR_W'(1)));

  assert_jump_target_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && cur_op == OP_JUMP) |=> (addr_o == $past(cur_tgt)));

  assert_halt_op_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && cur_op == OP_HALT) |=> (state_o == ST_HALT && addr_o == $past(start_addr_i)));

  assert_pause_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == ST_PAUSE && !halt_i) |=> $stable(addr_o));

  assert_pause_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == ST_PAUSE) |-> !valid_o);

  assert_halt_req_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o != ST_HALT && halt_i) |=> (state_o == ST_HALT && addr_o == $past(start_addr_i)));

  assert_start_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == ST_HALT && (start_i || trig_i)) |=> (state_o == ST_RUN));

  assert_ce_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == ST_RUN && !ce_i && !halt_i && !pause_i) |=> $stable(addr_o));
endmodule

bind vecseq_top vecseq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .ce_i         (ce_i),
  .start_i      (start_i),
  .trig_i       (trig_i),
  .pause_i      (pause_i),
  .halt_i       (halt_i),
  .start_addr_i (start_addr_i),
  .addr_o       (addr_o),
  .valid_o      (valid_o),
  .state_o      (state_o),
  .cur_op       (cur_op),
  .cur_tgt      (cur_tgt)
);

// File: tb/vecseq_top_tb_top.sv
`timescale 1ns/1ps
module vecseq_top_tb_top;
  localparam int ADDR_W = 6;
  localparam int CNT_W  = 16;
  localparam int CMD_W  = 3 + CNT_W + ADDR_W;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              ce_i = 1'b1, start_i = 1'b0, trig_i = 1'b0;
  logic              pause_i = 1'b0, resume_i = 1'b0, halt_i = 1'b0, cond_i = 1'b0;
  logic [ADDR_W-1:0] start_addr_i = '0;
  logic              cmd_we_i = 1'b0;
  logic [ADDR_W-1:0] cmd_waddr_i = '0;
  logic [CMD_W-1:0]  cmd_wdata_i = '0;
  logic [ADDR_W-1:0] addr_o;
  logic              valid_o;
  logic [1:0]        state_o;

  int total = 0;
  int bad   = 0;
  int got[$];

  always #2.5 clk_i = ~clk_i;

  vecseq_top #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) dut_i (.*);

  task automatic tick();
    @(negedge clk_i);
    #1;
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic wr(int a, int op, int cnt, int tgt);
    cmd_we_i    = 1'b1;
    cmd_waddr_i = ADDR_W'(a);
    cmd_wdata_i = {3'(op), 16'(cnt), 6'(tgt)};
    tick();
    cmd_we_i = 1'b0;
  endtask

  task automatic go(int sa, bit use_trig);
    start_addr_i = ADDR_W'(sa);
    if (use_trig) trig_i = 1'b1; else start_i = 1'b1;
    tick();
    start_i = 1'b0;
    trig_i  = 1'b0;
    #1;
  endtask

  task automatic run_cap(int maxn);
    got.delete();
    for (int c = 0; c < 200 && got.size() < maxn && state_o == 2'd2; c++) begin
      if (valid_o) got.push_back(int'(addr_o));
      tick();
    end
  endtask

  task automatic cmp_seq(string req, int e[$]);
    chk({req, " length"}, got.size(), e.size());
    foreach (e[i]) begin
      if (i < got.size()) chk({req, " addr"}, got[i], e[i]);
    end
  endtask

  task automatic t_reset();
    #1;
    chk("R1 state in reset", state_o, 0);
    chk("R1 valid in reset", valid_o, 0);
    chk("R1 addr in reset", addr_o, 0);
    rst_ni = 1'b1;
    tick();
    chk("R1 state after reset", state_o, 0);
    chk("R1 valid after reset", valid_o, 0);
  endtask

  task automatic t_linear();
    wr(4, 4, 0, 0);
    go(1, 1'b0);
    run_cap(16);
    cmp_seq("R3 R2 linear", '{1, 2, 3, 4});
    chk("R7 halted by opcode", state_o, 0);
    chk("R7 rewind to start", addr_o, 1);
    wr(2, 1, 0, 4);
    go(0, 1'b0);
    run_cap(16);
    cmp_seq("R12 rewritten word", '{0, 1, 2, 4});
    wr(2, 0, 0, 0);
  endtask

  task automatic t_branch();
    wr(10, 1, 0, 20);
    wr(20, 2, 0, 30);
    wr(21, 4, 0, 0);
    wr(30, 4, 0, 0);
    cond_i = 1'b1;
    go(10, 1'b0);
    run_cap(16);
    cmp_seq("R4 R5 cond high", '{10, 20, 30});
    cond_i = 1'b0;
    go(10, 1'b0);
    run_cap(16);
    cmp_seq("R5 cond low", '{10, 20, 21});
  endtask

  task automatic t_loop();
    wr(41, 3, 2, 40);
    wr(42, 4, 0, 0);
    go(40, 1'b0);
    run_cap(16);
    cmp_seq("R6 count two", '{40, 41, 40, 41, 40, 41, 42});
    go(40, 1'b0);
    run_cap(16);
    cmp_seq("R6 rerun", '{40, 41, 40, 41, 40, 41, 42});
    wr(50, 3, 0, 50);
    wr(51, 4, 0, 0);
    go(50, 1'b0);
    run_cap(16);
    cmp_seq("R6 count zero", '{50, 51});
    wr(46, 3, 1, 45);
    wr(47, 1, 0, 45);
    go(45, 1'b0);
    run_cap(10);
    cmp_seq("R6 reload in run", '{45, 46, 45, 46, 47, 45, 46, 45, 46, 47});
    halt_i = 1'b1;
    tick();
    halt_i = 1'b0;
    chk("R9 halt ends endless run", state_o, 0);
  endtask

  task automatic t_pause();
    go(0, 1'b0);
    tick();
    chk("R8 pre-pause addr", addr_o, 1);
    pause_i = 1'b1;
    #1;
    chk("R8 valid drops on request", valid_o, 0);
    tick();
    pause_i = 1'b0;
    #1;
    chk("R8 paused state", state_o, 1);
    chk("R8 frozen addr", addr_o, 1);
    tick(); tick(); tick();
    chk("R8 still frozen", addr_o, 1);
    chk("R8 no valid while paused", valid_o, 0);
    resume_i = 1'b1;
    tick();
    resume_i = 1'b0;
    #1;
    chk("R8 resumed state", state_o, 2);
    run_cap(16);
    cmp_seq("R8 continue", '{1, 2, 3, 4});
  endtask

  task automatic t_ce_halt();
    go(0, 1'b0);
    ce_i = 1'b0;
    #1;
    chk("R11 no valid without ce", valid_o, 0);
    tick(); tick();
    chk("R11 addr held", addr_o, 0);
    chk("R11 still running", state_o, 2);
    ce_i = 1'b1;
    #1;
    chk("R2 valid with ce", valid_o, 1);
    tick();
    chk("R11 step after ce", addr_o, 1);
    start_addr_i = 6'd5;
    halt_i  = 1'b1;
    pause_i = 1'b1;
    #1;
    chk("R9 no valid on halt", valid_o, 0);
    tick();
    halt_i  = 1'b0;
    pause_i = 1'b0;
    #1;
    chk("R9 halt beats pause", state_o, 0);
    chk("R9 rewind addr", addr_o, 5);
    go(0, 1'b0);
    pause_i = 1'b1;
    tick();
    pause_i = 1'b0;
    start_addr_i = 6'd3;
    halt_i = 1'b1;
    tick();
    halt_i = 1'b0;
    #1;
    chk("R9 halt from pause", state_o, 0);
    chk("R9 addr from pause", addr_o, 3);
  endtask

  task automatic t_trig();
    go(1, 1'b1);
    chk("R10 trigger starts", state_o, 2);
    chk("R10 first addr", addr_o, 1);
    run_cap(16);
    cmp_seq("R10 trigger run", '{1, 2, 3, 4});
  endtask

  initial begin
    #(5.0 * 150000);
    bad++;
    $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    for (int a = 0; a < (1 << ADDR_W); a++) wr(a, 0, 0, 0);
    t_linear();
    t_branch();
    t_loop();
    t_pause();
    t_ce_halt();
    t_trig();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule